// File: doc/BRIEF.md
# Dual-Width Bus Beat Sequencer

This block turns memory transfer requests into data beats on an external data bus. The bus runs either 64 or 32 bits wide, and a runtime mode input selects the width. Each request carries a start address, a byte count and a line-burst flag. The block checks the request and splits it into beats. Each beat carries its own address, lane byte enables and a final-beat marker. A simple responder takes beats with a ready signal.

The address tenure is reported as a one-cycle pulse that is separate from the data beats. At most two tenures can be open at once: the one whose data is moving and one pipelined address behind it. A request that would open a third tenure is held off until the current data tenure finishes. The width mode is taken only while nothing is outstanding. A mode change made during a transfer is used by the first request after the block goes idle.

Top module: `beat_seq`

## Requirements
- R1: In 64-bit mode (`wide_mode`=1), a single request of 1 to 8 bytes with `addr[2:0]`+count <= 8 produces one beat. The beat is at the request address with `dt_be` bit i set for byte lanes `addr[2:0]` through `addr[2:0]`+count-1, and `dt_last`=1.
- R2: In 64-bit mode, a burst request produces four beats. They start at the address rounded down to a 32-byte boundary and step by 8. Each beat has `dt_be`=8'hFF, and `dt_last` is set only on the fourth.
- R3: In 32-bit mode (`wide_mode`=0), a single request of 1 to 4 bytes with `addr[1:0]`+count <= 4 produces one beat. Its byte enables are set from lane `addr[1:0]` upward, bits 7:4 are zero, and `dt_last`=1.
- R4: In 32-bit mode, an 8-byte request with `addr[2:0]`=0 produces two beats at addr and addr+4. Each has `dt_be`=8'h0F, and the second has `dt_last`.
- R5: In 32-bit mode, a burst request produces eight beats from the 32-byte-aligned address, stepping by 4. Each has `dt_be`=8'h0F, and `dt_last` is set only on the eighth.
- R6: A non-burst request is rejected if its count is 0 or above 8, if it crosses the lane boundary of the current width, or if it is a 32-bit-mode request of 5 to 8 bytes that is not an aligned 8. A rejected request is consumed, gives `req_err`=1 in the next cycle only, and produces no address pulse and no beats.
- R7: An accepted request gives `at_valid`=1 for one cycle, in the cycle after acceptance. `at_addr` carries the first beat address and `at_burst` the burst flag.
- R8: `req_ready` is 0 exactly while two tenures are outstanding. A tenure counts from acceptance until its final beat is taken.
- R9: The width mode used for a request is the live `wide_mode` if no tenure is outstanding. Otherwise it is the value `wide_mode` had in the last idle cycle.
- R10: A beat offered with `dt_valid` and not taken (`dt_ready`=0) stays unchanged in the next cycle. Beats come out in request order.
- R11: After reset `dt_valid`, `at_valid` and `req_err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Start byte address |
| req_bytes | input | 4 | Byte count for a single transfer |
| req_burst | input | 1 | Cache-line burst request |
| req_err | output | 1 | Pulse: previous request was rejected |
| at_valid | output | 1 | Address tenure pulse |
| at_addr | output | 32 | Address of the tenure |
| at_burst | output | 1 | Tenure is a line burst |
| dt_valid | output | 1 | Data beat offered |
| dt_ready | input | 1 | Responder takes the beat |
| dt_addr | output | 32 | Beat address |
| dt_be | output | 8 | Beat byte-lane enables |
| dt_last | output | 1 | Final beat of the tenure |

## Verification
The bench aims at lane-crossing single transfers at offsets 6 and 7. A design with an off-by-one boundary test would either emit a beat whose enables wrap into the wrong lanes or reject a legal transfer. Unaligned 8-byte requests in 32-bit mode are also used. They expose a design that splits them into two beats instead of flagging an error. Back-to-back requests with the responder stalled test the two-tenure limit. A design that counts only queued addresses would accept a third request and lose or reorder its beats. The bench also flips the width mode while a burst is running. A design that reads the mode live would change beat stride and count partway through a tenure.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned LINE_B   = 32;
  localparam int unsigned WIDE_B   = 8;
  localparam int unsigned NARROW_B = 4;
  localparam int unsigned CW       = $clog2(LINE_B / NARROW_B) + 1;

  typedef struct packed {
    logic [AW-1:0]     addr;
    logic [CW-1:0]     beats;
    logic [WIDE_B-1:0] be;
    logic              wide;
  } tenure_t;
endpackage

// File: rtl/beat_seq_decode.sv
module beat_seq_decode
  import beat_seq_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [3:0]    nbytes,
  input  logic          burst,
  input  logic          wide,
  output tenure_t       ent,
  output logic          err
);
  localparam int unsigned WOB = $clog2(WIDE_B);
  localparam int unsigned NOB = $clog2(NARROW_B);

  logic [4:0]        end_w, end_n;
  logic [WIDE_B-1:0] mask;

  always_comb begin
    end_w = 5'(addr[WOB-1:0]) + 5'(nbytes);
    end_n = 5'(addr[NOB-1:0]) + 5'(nbytes);
    mask  = WIDE_B'((9'd1 << nbytes) - 9'd1);
    ent      = '0;
    ent.wide = wide;
    ent.addr = addr;
    err      = 1'b0;
    if (burst) begin
      ent.addr  = addr & ~AW'(LINE_B - 1);
      ent.beats = wide ? CW'(LINE_B / WIDE_B) : CW'(LINE_B / NARROW_B);
      ent.be    = wide ? '1 : WIDE_B'((1 << NARROW_B) - 1);
    end else if (nbytes == 4'd0 || nbytes > 4'(WIDE_B)) begin
      err = 1'b1;
    end else if (wide) begin
      err       = end_w > 5'(WIDE_B);
      ent.beats = CW'(1);
      ent.be    = mask << addr[WOB-1:0];
    end else if (nbytes == 4'(WIDE_B)) begin
      err       = addr[WOB-1:0] != '0;
      ent.beats = CW'(WIDE_B / NARROW_B);
      ent.be    = WIDE_B'((1 << NARROW_B) - 1);
    end else begin
      err       = end_n > 5'(NARROW_B);
      ent.beats = CW'(1);
      ent.be    = mask << addr[NOB-1:0];
    end
  end
endmodule

// File: rtl/beat_seq_tq.sv
module beat_seq_tq
  import beat_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  tenure_t       push_ent,
  input  logic          pop,
  output tenure_t       head,
  output logic [NW-1:0] count
);
  tenure_t       mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + NW'(push) - NW'(pop);
    end
  end

  assign head = mem[rp];

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < NW'(DEPTH)) || pop);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);
endmodule

// File: rtl/beat_seq_data.sv
module beat_seq_data
  import beat_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tenure_t       head,
  input  logic          head_valid,
  input  logic          dt_ready,
  output logic          dt_valid,
  output logic [AW-1:0] dt_addr,
  output logic [WIDE_B-1:0] dt_be,
  output logic          dt_last,
  output logic          done
);
  localparam int unsigned WSH = $clog2(WIDE_B);
  localparam int unsigned NSH = $clog2(NARROW_B);

  logic [CW-1:0] idx;
  logic          take;

  assign dt_valid = head_valid;
  assign dt_be    = head.be;
  assign dt_last  = head_valid && (idx == head.beats - 1'b1);
  assign dt_addr  = head.addr + (head.wide ? (AW'(idx) << WSH) : (AW'(idx) << NSH));
  assign take     = dt_valid && dt_ready;
  assign done     = take && dt_last;

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (done) idx <= '0;
    else if (take) idx <= idx + 1'b1;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (dt_valid && !dt_ready) |=> dt_valid && $stable(dt_addr) && $stable(dt_be) && $stable(dt_last));
  a_r2_last_valid: assert property (@(posedge clk) disable iff (rst)
    dt_last |-> dt_valid);
endmodule

// File: rtl/beat_seq.sv
module beat_seq
  import beat_seq_pkg::*;
#(
  parameter int unsigned OUTSTANDING = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_bytes,
  input  logic              req_burst,
  output logic              req_err,
  output logic              at_valid,
  output logic [AW-1:0]     at_addr,
  output logic              at_burst,
  output logic              dt_valid,
  input  logic              dt_ready,
  output logic [AW-1:0]     dt_addr,
  output logic [WIDE_B-1:0] dt_be,
  output logic              dt_last
);
  localparam int unsigned NW = $clog2(OUTSTANDING + 1);

  tenure_t       ent, head;
  logic          dec_err, accept, push, done, busy, mode_q, mode_eff;
  logic [NW-1:0] cnt;

  assign busy      = cnt != '0;
  assign mode_eff  = busy ? mode_q : wide_mode;
  assign req_ready = cnt < NW'(OUTSTANDING);
  assign accept    = req_valid && req_ready;
  assign push      = accept && !dec_err;

  beat_seq_decode u_dec (
    .addr(req_addr), .nbytes(req_bytes), .burst(req_burst),
    .wide(mode_eff), .ent(ent), .err(dec_err)
  );

  beat_seq_tq #(.DEPTH(OUTSTANDING)) u_tq (
    .clk(clk), .rst(rst), .push(push), .push_ent(ent),
    .pop(done), .head(head), .count(cnt)
  );

  beat_seq_data u_data (
    .clk(clk), .rst(rst), .head(head), .head_valid(busy), .dt_ready(dt_ready),
    .dt_valid(dt_valid), .dt_addr(dt_addr), .dt_be(dt_be), .dt_last(dt_last),
    .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b1;
      at_valid <= 1'b0;
      at_addr  <= '0;
      at_burst <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      if (!busy) mode_q <= wide_mode;
      at_valid <= push;
      req_err  <= accept && dec_err;
      if (push) begin
        at_addr  <= ent.addr;
        at_burst <= req_burst;
      end
    end
  end

  a_r7_at_after_accept: assert property (@(posedge clk) disable iff (rst)
    at_valid |-> $past(req_valid && req_ready));
  a_r6_err_no_at: assert property (@(posedge clk) disable iff (rst)
    req_err |-> !at_valid);
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q));
  a_r8_stall_when_full: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(push) && $past(busy) && !$past(done)) |-> !req_ready);
endmodule

// File: tb/beat_seq_tb.sv
module beat_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 0, rst = 1;
  logic wide_mode = 1, req_valid = 0, req_burst = 0, dt_ready = 0;
  logic [31:0] req_addr = 0;
  logic [3:0]  req_bytes = 0;
  logic req_ready, req_err, at_valid, at_burst, dt_valid, dt_last;
  logic [31:0] at_addr, dt_addr;
  logic [7:0]  dt_be;

  int vectors = 0, fails = 0;

  beat_seq dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_bytes(req_bytes),
    .req_burst(req_burst), .req_err(req_err), .at_valid(at_valid),
    .at_addr(at_addr), .at_burst(at_burst), .dt_valid(dt_valid),
    .dt_ready(dt_ready), .dt_addr(dt_addr), .dt_be(dt_be), .dt_last(dt_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [31:0] q_addr[$];
  logic [7:0]  q_be[$];
  logic        q_last[$];
  string       q_tag[$];
  int          m_cnt = 0;
  logic        m_mode = 1;
  logic        exp_at = 0, exp_atb = 0, exp_err = 0;
  logic [31:0] exp_ata = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lanes(input int off, input int n);
    logic [7:0] m = 0;
    for (int i = 0; i < n; i++) m[off + i] = 1'b1;
    return m;
  endfunction

  // one cycle: check state seen now, drive inputs, predict next state
  task automatic step(input bit rv, input logic [31:0] a, input logic [3:0] nb,
                      input bit bu, input bit wm, input bit rdy);
    bit acc, hs, md, er;
    int nbeats, stride;
    logic [7:0] be;
    logic [31:0] base;
    string tg;
    chk(at_valid == exp_at, "R7 at_valid", at_valid, exp_at);
    if (exp_at) begin
      chk(at_addr == exp_ata, "R7 at_addr", at_addr, exp_ata);
      chk(at_burst == exp_atb, "R7 at_burst", at_burst, exp_atb);
    end
    chk(req_err == exp_err, "R6 req_err", req_err, exp_err);
    chk(req_ready == (m_cnt < 2), "R8 req_ready", req_ready, m_cnt < 2);
    chk(dt_valid == (q_addr.size() != 0), "R10 dt_valid", dt_valid, q_addr.size() != 0);
    if (q_addr.size() != 0 && dt_valid) begin
      chk(dt_addr == q_addr[0], {q_tag[0], " dt_addr"}, dt_addr, q_addr[0]);
      chk(dt_be == q_be[0], {q_tag[0], " dt_be"}, dt_be, q_be[0]);
      chk(dt_last == q_last[0], {q_tag[0], " dt_last"}, dt_last, q_last[0]);
    end
    req_valid = rv; req_addr = a; req_bytes = nb; req_burst = bu;
    wide_mode = wm; dt_ready = rdy;
    hs  = dt_valid && rdy && q_addr.size() != 0;
    acc = rv && (m_cnt < 2);
    md  = (m_cnt == 0) ? wm : m_mode; // R9
    if (m_cnt == 0) m_mode = wm;
    exp_at = 0; exp_err = 0;
    if (hs) begin
      if (q_last[0]) m_cnt--;
      void'(q_addr.pop_front()); void'(q_be.pop_front());
      void'(q_last.pop_front()); void'(q_tag.pop_front());
    end
    if (acc) begin
      er = 0; base = a; nbeats = 1; stride = md ? 8 : 4; be = 0; tg = "";
      if (bu) begin
        base = {a[31:5], 5'd0}; nbeats = md ? 4 : 8;
        be = md ? 8'hFF : 8'h0F; tg = md ? "R2" : "R5";
      end else if (nb == 0 || nb > 8) er = 1;
      else if (md) begin
        if (int'(a[2:0]) + int'(nb) > 8) er = 1; else be = lanes(int'(a[2:0]), int'(nb));
        tg = "R1";
      end else if (nb == 8) begin
        if (a[2:0] != 0) er = 1; else begin nbeats = 2; be = 8'h0F; end
        tg = "R4";
      end else begin
        if (int'(a[1:0]) + int'(nb) > 4) er = 1; else be = lanes(int'(a[1:0]), int'(nb));
        tg = "R3";
      end
      if (er) exp_err = 1;
      else begin
        m_cnt++;
        exp_at = 1; exp_ata = base; exp_atb = bu;
        for (int k = 0; k < nbeats; k++) begin
          q_addr.push_back(base + 32'(k * stride));
          q_be.push_back(be);
          q_last.push_back(k == nbeats - 1);
          q_tag.push_back(tg);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic drain(input bit wm);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, wm, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    chk(dt_valid == 0, "R11 dt_valid", dt_valid, 0);
    chk(at_valid == 0, "R11 at_valid", at_valid, 0);
    chk(req_err == 0, "R11 req_err", req_err, 0);
    chk(req_ready == 1, "R11 req_ready", req_ready, 1);
    // directed corners
    step(1, 32'h105, 4'd3, 0, 1, 1); drain(1);     // R1 off 5, be E0
    step(1, 32'h106, 4'd3, 0, 1, 1); drain(1);     // R6 wide crossing
    step(1, 32'h200, 4'd8, 0, 1, 1); drain(1);     // R1 full 8
    step(1, 32'h1234, 4'd0, 1, 1, 1); drain(1);    // R2 unaligned burst
    step(1, 32'h40, 4'd8, 0, 0, 1); drain(0);      // R4 aligned 8 narrow
    step(1, 32'h44, 4'd8, 0, 0, 1); drain(0);      // R6 misaligned 8
    step(1, 32'h40, 4'd6, 0, 0, 1); drain(0);      // R6 narrow 6 bytes
    step(1, 32'h43, 4'd2, 0, 0, 1); drain(0);      // R6 narrow crossing
    step(1, 32'h42, 4'd2, 0, 0, 1); drain(0);      // R3 lanes 3:2
    step(1, 32'h77, 4'd0, 1, 0, 1); drain(0);      // R5 narrow burst
    step(1, 32'h10, 4'd0, 0, 1, 1); drain(1);      // R6 zero count
    step(1, 32'h10, 4'd9, 0, 1, 1); drain(1);      // R6 over 8
    // R8 stall: three requests with responder stalled
    step(1, 32'h300, 4'd0, 1, 1, 0);
    step(1, 32'h400, 4'd0, 1, 1, 0);
    step(1, 32'h500, 4'd0, 1, 1, 0);
    step(1, 32'h500, 4'd0, 1, 0, 0);               // R9 mode flip while busy
    for (int i = 0; i < 6; i++) step(1, 32'h500, 4'd0, 1, 0, i[0]);
    drain(0);
    // constrained random
    for (int i = 0; i < RAND_CYCLES; i++) begin
      int r = $urandom % 16;
      logic [3:0] nb = (r < 12) ? 4'($urandom % 8 + 1) : 4'($urandom % 16);
      step(($urandom % 3) != 0, $urandom, nb, ($urandom % 4) == 0,
           (($urandom % 20) == 0) ? !wide_mode : wide_mode, ($urandom % 4) != 0);
    end
    drain(wide_mode);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial void'($urandom(32'd7));
endmodule